// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Core

This block is a watchdog timer that counts down in two consecutive stages. A first stage runs from one 20-bit preload. If software does not ping before it runs out, the block issues a selectable first-stage action: an interrupt request pulse, a system-management interrupt pulse, or nothing. It then starts a second stage from a second 20-bit preload. If the second stage also runs out and reboot is enabled, the block pulses a system reset request. It also sets a sticky previous-reboot flag and returns its own configuration to the reset defaults. With reboot disabled, the block either stops in stage 2 or, in free-run mode, starts stage 1 again.

Each stage's length in base-clock cycles is its preload shifted left. The shift is 15 in slow-scale mode and 5 in fast-scale mode. Configuration arrives through four write strobes that latch the mode fields, the control fields and the two preloads. Register decoding, bus access and the reset logic that consumes the request are outside the block.

Top module: `wdog_two_stage`

## Requirements
- R1: After rst_n is low at a clock edge, stage reads 1, all three pulse outputs are 0, the block is disabled, both preloads are all ones, the scale is slow, the action type is 0 (IRQ), reboot is enabled and free-run is off.
- R2: A stage started at clock edge E ends at edge E+L, where L is its preload shifted left by 15 (mode_fast=0) or by 5 (mode_fast=1). A stage whose L is 0 lasts one cycle.
- R3: A ctl_wr with ctl_enable=1 starts stage 1 from preload 1 only if the block was disabled. Rewriting enable=1 while enabled does not restart the count. A ctl_wr with ctl_enable=0 stops counting.
- R4: A ping while enabled restarts stage 1 from preload 1. A ping while disabled has no effect.
- R5: When stage 1 ends, the action type selects the output: code 0 pulses irq_pulse, code 2 pulses smi_pulse, and codes 1 and 3 pulse nothing. In every case stage becomes 2 and counts from preload 2.
- R6: When stage 2 ends with reboot enabled, sysrst_pulse and reboot_flag rise after the same edge. The block returns to stage 1, disabled, with every configuration field at its R1 default.
- R7: When stage 2 ends with reboot disabled, free-run on restarts stage 1 from preload 1. Free-run off leaves the block stopped at stage 2 with no further pulses.
- R8: reboot_flag keeps its value through rst_n. It is cleared only by flag_clr, and a setting event in the same cycle wins over the clear.
- R9: Each pulse output is high for exactly one cycle, and at most one pulse output is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_wr | input | 1 | Latch the mode fields |
| mode_fast | input | 1 | Scale select: 1 gives shift 5, 0 gives shift 15 |
| mode_itype | input | 2 | First-stage action code (0 IRQ, 2 SMI, 1/3 none) |
| mode_reboot_en | input | 1 | Request a reset when stage 2 ends |
| ctl_wr | input | 1 | Latch enable and free-run |
| ctl_enable | input | 1 | Enable value for ctl_wr |
| ctl_free_run | input | 1 | Free-run value for ctl_wr |
| pre1_wr | input | 1 | Latch pre_val as the stage 1 preload |
| pre2_wr | input | 1 | Latch pre_val as the stage 2 preload |
| pre_val | input | 20 | Preload value |
| ping | input | 1 | Keep-alive strobe |
| flag_clr | input | 1 | Clear the previous-reboot flag |
| irq_pulse | output | 1 | First-stage interrupt request pulse |
| smi_pulse | output | 1 | First-stage management interrupt pulse |
| sysrst_pulse | output | 1 | System reset request pulse |
| stage | output | 2 | Current stage, 1 or 2 |
| reboot_flag | output | 1 | Sticky previous-reboot flag |

## Verification
The countdown is exercised with short fast-scale preloads and with one slow-scale preload. The slow run separates the two shift amounts and shows that the scale and action defaults come back after a reboot. The action code is swept through 0, 2 and 3, so a mix-up between IRQ, SMI and silent expiry shows as a wrong pulse or a missing stage change. The stage 2 outcome is tried with reboot enabled, with reboot disabled and free-run off, and with reboot disabled and free-run on. A ping mid-stage, a ping while disabled and a repeated enable write each show whether restarts are keyed to the right events.

// File: rtl/wdog_pkg.sv
// Package: shared types for the two-stage watchdog.
// Assumes: action codes are 2 bits; code 1 behaves as no action.
package wdog_pkg;
    typedef enum logic [1:0] {
        ITYPE_IRQ  = 2'd0,
        ITYPE_RSVD = 2'd1,
        ITYPE_SMI  = 2'd2,
        ITYPE_NONE = 2'd3
    } itype_e;

    typedef struct packed {
        logic   fast;
        itype_e itype;
        logic   reboot_en;
        logic   free_run;
        logic   enable;
    } wd_mode_t;
endpackage

// File: rtl/wdog_cfg_regs.sv
// Module: configuration latches for the watchdog.
// Holds mode, control and preload fields. Restores them all to their
// defaults when the restore input is high, which takes priority over writes.
// Derives start (enable rising) and stop (enable written low) strobes.
// Assumes: restore is only raised when neither start nor stop is active.
module wdog_cfg_regs
    import wdog_pkg::*;
#(
    parameter int PRE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_fast,
    input  logic [1:0]       mode_itype,
    input  logic             mode_reboot_en,
    input  logic             ctl_wr,
    input  logic             ctl_enable,
    input  logic             ctl_free_run,
    input  logic             pre1_wr,
    input  logic             pre2_wr,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             restore,
    output wd_mode_t         mode,
    output logic [PRE_W-1:0] pre1,
    output logic [PRE_W-1:0] pre2,
    output logic             start,
    output logic             stop
);
    localparam logic [PRE_W-1:0] PRE_DEFAULT = {PRE_W{1'b1}};
    localparam wd_mode_t MODE_DEFAULT = '{fast: 1'b0, itype: ITYPE_IRQ,
        reboot_en: 1'b1, free_run: 1'b0, enable: 1'b0};

    // Start on a 0->1 enable write; stop on any enable=0 write.
    always_comb begin
        start = ctl_wr && ctl_enable && !mode.enable;
        stop  = ctl_wr && !ctl_enable;
    end

    // Latch fields; reset or reboot restore returns defaults.
    always_ff @(posedge clk) begin
        if (!rst_n || restore) begin
            mode <= MODE_DEFAULT;
            pre1 <= PRE_DEFAULT;
            pre2 <= PRE_DEFAULT;
        end else begin
            if (mode_wr) begin
                mode.fast      <= mode_fast;
                mode.itype     <= itype_e'(mode_itype);
                mode.reboot_en <= mode_reboot_en;
            end
            if (ctl_wr) begin
                mode.enable   <= ctl_enable;
                mode.free_run <= ctl_free_run;
            end
            if (pre1_wr) pre1 <= pre_val;
            if (pre2_wr) pre2 <= pre_val;
        end
    end

    assert_restore_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> (!mode.enable && mode.itype == ITYPE_IRQ && mode.reboot_en
                     && !mode.fast && !mode.free_run && pre1 == PRE_DEFAULT));

    assert_start_sets_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mode.enable);
endmodule

// File: rtl/wdog_stage_ctrl.sv
// Module: two-stage countdown sequencer.
// Loads the counter with preload << shift at each stage start and counts
// down. On expiry it issues the stage 1 action, or the stage 2 reboot,
// free-run restart or stop. Pulses are registered and one cycle wide.
// Priority: stop > restart (start or enabled ping) > expiry > count.
module wdog_stage_ctrl
    import wdog_pkg::*;
#(
    parameter int PRE_W      = 20,
    parameter int SHIFT_SLOW = 15,
    parameter int SHIFT_FAST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wd_mode_t         mode,
    input  logic [PRE_W-1:0] pre1,
    input  logic [PRE_W-1:0] pre2,
    input  logic             start,
    input  logic             stop,
    input  logic             ping,
    output logic             stage_two,
    output logic             irq_q,
    output logic             smi_q,
    output logic             rst_q,
    output logic             reboot_evt
);
    localparam int CNT_W = PRE_W + SHIFT_SLOW;

    logic             running;
    logic [CNT_W-1:0] cnt;
    logic             restart, expire, s1_exp, s2_exp;
    logic [CNT_W-1:0] load1, load2;

    // Convert a preload into a cycle count under the selected scale.
    function automatic logic [CNT_W-1:0] scaled(input logic [PRE_W-1:0] p,
                                                input logic fast);
        logic [CNT_W-1:0] w;
        w = CNT_W'(p);
        return fast ? (w << SHIFT_FAST) : (w << SHIFT_SLOW);
    endfunction

    // Decode restart and expiry events for this cycle.
    always_comb begin
        load1      = scaled(pre1, mode.fast);
        load2      = scaled(pre2, mode.fast);
        restart    = start || (ping && mode.enable);
        expire     = running && (cnt <= CNT_W'(1)) && !stop && !restart;
        s1_exp     = expire && !stage_two;
        s2_exp     = expire && stage_two;
        reboot_evt = s2_exp && mode.reboot_en;
    end

    // Counter, stage and pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            stage_two <= 1'b0;
            cnt       <= '0;
            irq_q     <= 1'b0;
            smi_q     <= 1'b0;
            rst_q     <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            smi_q <= 1'b0;
            rst_q <= 1'b0;
            if (stop) begin
                running <= 1'b0;
            end else if (restart) begin
                running   <= 1'b1;
                stage_two <= 1'b0;
                cnt       <= load1;
            end else if (s1_exp) begin
                stage_two <= 1'b1;
                cnt       <= load2;
                irq_q     <= (mode.itype == ITYPE_IRQ);
                smi_q     <= (mode.itype == ITYPE_SMI);
            end else if (s2_exp) begin
                if (mode.reboot_en) begin
                    rst_q     <= 1'b1;
                    running   <= 1'b0;
                    stage_two <= 1'b0;
                end else if (mode.free_run) begin
                    stage_two <= 1'b0;
                    cnt       <= load1;
                end else begin
                    running <= 1'b0;
                end
            end else if (running) begin
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !running);

    assert_action_in_stage2_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || smi_q) |-> (stage_two && running));

    assert_reboot_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (!stage_two && !running));

    assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q || smi_q || rst_q) |=> !(irq_q || smi_q || rst_q));

    assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_q, smi_q, rst_q}));
endmodule

// File: rtl/wdog_reboot_flag.sv
// Module: sticky previous-reboot flag.
// Not touched by the block reset, so it survives the reset that a reboot
// request causes. Starts at 0 through its power-up value. A set event
// wins over a clear in the same cycle.
module wdog_reboot_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q = 1'b0;

    // Set on reboot event, clear on explicit request only.
    always_ff @(posedge clk) begin
        if (set)      flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag = flag_q;

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/wdog_two_stage.sv
// Module: top of the two-stage watchdog countdown core.
// Joins the configuration latches, the stage sequencer and the sticky flag.
// Assumes: all strobes are synchronous to clk and one cycle wide.
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int PRE_W      = 20,
    parameter int SHIFT_SLOW = 15,
    parameter int SHIFT_FAST = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic             mode_fast,
    input  logic [1:0]       mode_itype,
    input  logic             mode_reboot_en,
    input  logic             ctl_wr,
    input  logic             ctl_enable,
    input  logic             ctl_free_run,
    input  logic             pre1_wr,
    input  logic             pre2_wr,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             ping,
    input  logic             flag_clr,
    output logic             irq_pulse,
    output logic             smi_pulse,
    output logic             sysrst_pulse,
    output logic [1:0]       stage,
    output logic             reboot_flag
);
    wd_mode_t         mode;
    logic [PRE_W-1:0] pre1, pre2;
    logic             start, stop, stage_two, reboot_evt;

    wdog_cfg_regs #(.PRE_W(PRE_W)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .mode_wr(mode_wr), .mode_fast(mode_fast), .mode_itype(mode_itype),
        .mode_reboot_en(mode_reboot_en),
        .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_free_run(ctl_free_run),
        .pre1_wr(pre1_wr), .pre2_wr(pre2_wr), .pre_val(pre_val),
        .restore(reboot_evt),
        .mode(mode), .pre1(pre1), .pre2(pre2), .start(start), .stop(stop)
    );

    wdog_stage_ctrl #(.PRE_W(PRE_W), .SHIFT_SLOW(SHIFT_SLOW),
                      .SHIFT_FAST(SHIFT_FAST)) seq_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pre1(pre1), .pre2(pre2),
        .start(start), .stop(stop), .ping(ping),
        .stage_two(stage_two), .irq_q(irq_pulse), .smi_q(smi_pulse),
        .rst_q(sysrst_pulse), .reboot_evt(reboot_evt)
    );

    wdog_reboot_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set(reboot_evt), .clr(flag_clr),
        .flag(reboot_flag)
    );

    // Present the stage as the number 1 or 2.
    assign stage = stage_two ? 2'd2 : 2'd1;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (stage == 2'd1 && !irq_pulse && !smi_pulse && !sysrst_pulse));

    assert_flag_with_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_pulse |-> reboot_flag);
endmodule

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wr = 0, mode_fast = 0, mode_reboot_en = 0;
    logic [1:0]  mode_itype = 0;
    logic        ctl_wr = 0, ctl_enable = 0, ctl_free_run = 0;
    logic        pre1_wr = 0, pre2_wr = 0, ping = 0, flag_clr = 0;
    logic [19:0] pre_val = 0;
    logic        irq_pulse, smi_pulse, sysrst_pulse, reboot_flag;
    logic [1:0]  stage;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    wdog_two_stage dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_fast(mode_fast),
        .mode_itype(mode_itype), .mode_reboot_en(mode_reboot_en),
        .ctl_wr(ctl_wr), .ctl_enable(ctl_enable), .ctl_free_run(ctl_free_run),
        .pre1_wr(pre1_wr), .pre2_wr(pre2_wr), .pre_val(pre_val), .ping(ping),
        .flag_clr(flag_clr), .irq_pulse(irq_pulse), .smi_pulse(smi_pulse),
        .sysrst_pulse(sysrst_pulse), .stage(stage), .reboot_flag(reboot_flag)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_mode(input logic fast, input logic [1:0] it, input logic rb);
        @(negedge clk);
        mode_wr = 1; mode_fast = fast; mode_itype = it; mode_reboot_en = rb;
        @(negedge clk); mode_wr = 0;
    endtask

    task automatic wr_ctl(input logic en, input logic fr);
        @(negedge clk);
        ctl_wr = 1; ctl_enable = en; ctl_free_run = fr;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic wr_pre(input logic [19:0] p1, input logic [19:0] p2);
        @(negedge clk); pre1_wr = 1; pre_val = p1;
        @(negedge clk); pre1_wr = 0; pre2_wr = 1; pre_val = p2;
        @(negedge clk); pre2_wr = 0;
    endtask

    task automatic do_ping();
        @(negedge clk); ping = 1;
        @(negedge clk); ping = 0;
    endtask

    task automatic do_clr();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0:       return irq_pulse;
            1:       return smi_pulse;
            default: return sysrst_pulse;
        endcase
    endfunction

    // Sample each cycle until the selected pulse; report cycle and other pulses.
    task automatic wait_pulse(input int sel, input int limit,
                              output int n, output int others);
        n = -1; others = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (pick(sel)) begin
                n = i;
                others += int'(irq_pulse) + int'(smi_pulse) + int'(sysrst_pulse) - 1;
                break;
            end
            others += int'(irq_pulse) + int'(smi_pulse) + int'(sysrst_pulse);
        end
    endtask

    task automatic run_cycles(input int cyc, output int pulses);
        pulses = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            pulses += int'(irq_pulse) + int'(smi_pulse) + int'(sysrst_pulse);
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "stage", stage, 1);
        chk("R1", "irq", irq_pulse, 0);
        chk("R1", "smi", smi_pulse, 0);
        chk("R1", "sysrst", sysrst_pulse, 0);
        do_clr();
        chk("R8", "flag after clear", reboot_flag, 0);
    endtask

    task automatic t_fast_reboot();
        int n, o, p;
        wr_mode(1, 2'd0, 1);
        wr_pre(20'd3, 20'd2);
        wr_ctl(1, 0);
        wait_pulse(0, 200, n, o);
        chk("R2", "stage1 length fast", n, 96);
        chk("R5", "stage after irq", stage, 2);
        wait_pulse(2, 200, n, o);
        chk("R2", "stage2 length fast", n, 64);
        chk("R9", "other pulses before reset", o, 0);
        chk("R6", "flag with reset pulse", reboot_flag, 1);
        chk("R6", "stage after reboot", stage, 1);
        run_cycles(300, p);
        chk("R6", "stopped after reboot", p, 0);
    endtask

    task automatic t_slow_defaults();
        int n, o;
        wr_pre(20'd1, 20'd1);
        wr_ctl(1, 0);
        wait_pulse(0, 40000, n, o);
        chk("R2", "slow default scale", n, 32768);
        chk("R6", "default action irq", o, 0);
        wr_ctl(0, 0);
    endtask

    task automatic t_flag_survives();
        do_reset();
        chk("R8", "flag kept through reset", reboot_flag, 1);
        chk("R1", "stage after reset", stage, 1);
        do_clr();
        chk("R8", "flag cleared", reboot_flag, 0);
    endtask

    task automatic t_smi_stop();
        int n, o, p;
        wr_mode(1, 2'd2, 0);
        wr_pre(20'd2, 20'd1);
        wr_ctl(1, 0);
        wait_pulse(1, 200, n, o);
        chk("R5", "smi timing", n, 64);
        chk("R5", "no irq with smi", o, 0);
        run_cycles(100, p);
        chk("R7", "no pulses after stage2 stop", p, 0);
        chk("R7", "stays stage 2", stage, 2);
        chk("R7", "flag unchanged", reboot_flag, 0);
        wr_ctl(0, 0);
    endtask

    task automatic t_none();
        int p1, p2;
        wr_mode(1, 2'd3, 0);
        wr_pre(20'd2, 20'd1);
        wr_ctl(1, 0);
        run_cycles(63, p1);
        chk("R5", "stage before silent expiry", stage, 1);
        run_cycles(1, p2);
        chk("R5", "stage after silent expiry", stage, 2);
        chk("R5", "no pulse for code 3", p1 + p2, 0);
        wr_ctl(0, 0);
    endtask

    task automatic t_free_run();
        int n, o;
        wr_mode(1, 2'd0, 0);
        wr_pre(20'd2, 20'd1);
        wr_ctl(1, 1);
        wait_pulse(0, 200, n, o);
        chk("R7", "first irq", n, 64);
        wait_pulse(0, 300, n, o);
        chk("R7", "free-run second irq", n, 96);
        chk("R7", "no reset in free-run", o, 0);
        wr_ctl(0, 0);
    endtask

    task automatic t_ping();
        int n, o, p;
        wr_mode(1, 2'd0, 0);
        wr_pre(20'd3, 20'd1);
        wr_ctl(1, 0);
        run_cycles(50, p);
        chk("R4", "quiet before ping", p, 0);
        do_ping();
        wait_pulse(0, 200, n, o);
        chk("R4", "irq after ping restart", n, 96);
        wr_ctl(0, 0);
        do_ping();
        run_cycles(200, p);
        chk("R4", "ping while disabled ignored", p, 0);
        chk("R3", "stop holds stage", stage, 2);
    endtask

    task automatic t_reenable();
        int n, o, p;
        wr_pre(20'd3, 20'd1);
        wr_ctl(1, 0);
        run_cycles(50, p);
        wr_ctl(1, 0);
        wait_pulse(0, 200, n, o);
        chk("R3", "rewrite enable no restart", n, 44);
        wr_ctl(0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fast_reboot();
        t_slow_defaults();
        t_flag_survives();
        t_smi_stop();
        t_none();
        t_free_run();
        t_ping();
        t_reenable();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule